// File: doc/BRIEF.md
# Two-Level USB Interrupt Aggregator

This block collects the one-cycle event pulses from a USB device controller and turns them into a single interrupt request for the processor. Each event latches a sticky flag. Each flag has its own enable bit. Flag bits and enable bits are kept in separate registers, in two tiers.

The lower tier holds six error conditions. When any lower-tier flag is set and its enable bit is also set, a summary error flag in the upper tier is set. The upper tier holds six status events plus that summary flag. The request line to the processor is the registered OR of the upper-tier flags that are enabled.

Software works through a small register port. Flags are cleared by writing 1 to them (write-1-to-clear). Enable registers are written directly. Every register can be read back.

Top module: `usb_irq_funnel`

## Requirements
- R1: The register port decodes `reg_addr_i` as follows: 0 selects the status flags, 1 the status enables, 2 the error flags and 3 the error enables. `reg_rdata_o` shows the addressed register at once, and any bit above the register's width reads as 0.
- R2: Status tier bit positions are fixed. Bits 0 to 5 are bus reset, start-of-frame, transaction complete, idle, stall and bus activity, and `stat_evt_i[k]` sets status flag k. Bit 6 is the error summary.
- R3: Error tier bit positions are fixed: 0 PID check, 1 CRC5, 2 CRC16, 3 data-field bit count, 4 turnaround timeout and 5 bit-stuff. `err_evt_i[k]` sets error flag k.
- R4: An event pulse sets its flag at the next clock edge, whatever the state of that flag's enable bit.
- R5: A write to a flag register clears each flag whose data bit is 1 and leaves flags under 0 bits unchanged. A write to an enable register loads it, and an enable register changes only when it is written.
- R6: If an event and a write-1-to-clear hit the same flag in the same cycle, the flag stays set.
- R7: The summary flag (status bit 6) is set at the clock edge after any error flag is set while its enable bit is set. An error flag whose enable bit is clear never sets it. Enabling an error flag that is already set does set it.
- R8: While any enabled error flag remains set, writing 1 to the summary flag does not clear it. Once those error flags are cleared, the same write does clear it.
- R9: `irq_o` equals the OR of all status flags that are enabled, as they stood one clock earlier. It therefore rises or falls one clock after the flag or enable change that causes it.
- R10: Reset clears all flags, all enables and `irq_o` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stat_evt_i | input | 6 | Status event pulses, bit layout as in R2 |
| err_evt_i | input | 6 | Error event pulses, bit layout as in R3 |
| reg_addr_i | input | 2 | Register select |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data of the selected register |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The funnel is tried with four kinds of input pattern:
- **Lone status events with the enable off, then on.** These separate latching from request generation, and they expose the one-clock request latency.
- **Error events through enabled and disabled error bits.** These show the two-clock path from an error pulse to the summary flag and the request. They also show that a masked error stays out of the upper tier until it is enabled later.
- **Clears that collide with events, and clears of the summary flag before and after its error source is cleared.** These separate the set-wins priority from plain write-1-to-clear.
- **Several enabled flags cleared one at a time.** This shows that the request is an OR and falls only when the last enabled flag is cleared.

// File: rtl/usb_irq_pkg.sv
`timescale 1ns/1ps
package usb_irq_pkg;

   typedef enum logic [1:0] {
      RA_STAT_FLAG = 2'd0,
      RA_STAT_EN   = 2'd1,
      RA_ERR_FLAG  = 2'd2,
      RA_ERR_EN    = 2'd3
   } reg_addr_e;

   // status tier bit positions (summary sits above the event-driven bits)
   localparam int ST_BUS_RESET = 0;
   localparam int ST_SOF       = 1;
   localparam int ST_XACT_DONE = 2;
   localparam int ST_IDLE      = 3;
   localparam int ST_STALL     = 4;
   localparam int ST_ACTIVITY  = 5;

   // error tier bit positions
   localparam int ER_PID       = 0;
   localparam int ER_CRC5      = 1;
   localparam int ER_CRC16     = 2;
   localparam int ER_BITCOUNT  = 3;
   localparam int ER_TURNAR    = 4;
   localparam int ER_BITSTUFF  = 5;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/usb_irq_bank.sv
`timescale 1ns/1ps
module usb_irq_bank #(
   parameter int W = 6
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [W-1:0] set_i,
   input  logic         clr_wr_i,
   input  logic [W-1:0] clr_mask_i,
   input  logic         en_wr_i,
   input  logic [W-1:0] en_data_i,
   output logic [W-1:0] flag_o,
   output logic [W-1:0] en_o,
   output logic         pend_o
);

   if (W < 1) begin : g_bad_width
      $error("usb_irq_bank: W must be at least 1");
   end

   logic [W-1:0] flag_q;
   logic [W-1:0] en_q;
   logic [W-1:0] clr_eff;

   assign clr_eff = clr_wr_i ? clr_mask_i : '0;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         flag_q <= '0;
      end else begin
         // set has priority over a simultaneous clear
         flag_q <= (flag_q & ~clr_eff) | set_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q <= '0;
      end else if (en_wr_i) begin
         en_q <= en_data_i;
      end
   end

   assign flag_o = flag_q;
   assign en_o   = en_q;
   assign pend_o = |(flag_q & en_q);

   for (genvar i = 0; i < W; i++) begin : g_bit_chk
      // R4 R6
      flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         set_i[i] |=> flag_q[i]);

      // R5
      flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (clr_wr_i && clr_mask_i[i] && !set_i[i]) |=> !flag_q[i]);
   end

   // R5
   en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_wr_i |=> $stable(en_q));

endmodule

// File: rtl/usb_irq_regif.sv
`timescale 1ns/1ps
module usb_irq_regif
   import usb_irq_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int STAT_N = 7,
   parameter int ERR_N  = 6
) (
   input  logic [1:0]        addr_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [STAT_N-1:0] stat_flag_i,
   input  logic [STAT_N-1:0] stat_en_i,
   input  logic [ERR_N-1:0]  err_flag_i,
   input  logic [ERR_N-1:0]  err_en_i,
   output logic              stat_clr_wr_o,
   output logic              stat_en_wr_o,
   output logic              err_clr_wr_o,
   output logic              err_en_wr_o,
   output logic [STAT_N-1:0] stat_data_o,
   output logic [ERR_N-1:0]  err_data_o,
   output logic [DATA_W-1:0] rdata_o
);

   localparam int MAX_N = max_of(STAT_N, ERR_N);

   if (DATA_W < MAX_N) begin : g_bad_data_w
      $error("usb_irq_regif: DATA_W narrower than a tier");
   end

   if (DATA_W > MAX_N) begin : g_spare_bits
      logic unused_wbits;
      assign unused_wbits = ^wdata_i[DATA_W-1:MAX_N];
   end

   reg_addr_e sel;
   assign sel = reg_addr_e'(addr_i);

   assign stat_clr_wr_o = wr_i && (sel == RA_STAT_FLAG);
   assign stat_en_wr_o  = wr_i && (sel == RA_STAT_EN);
   assign err_clr_wr_o  = wr_i && (sel == RA_ERR_FLAG);
   assign err_en_wr_o   = wr_i && (sel == RA_ERR_EN);

   assign stat_data_o = wdata_i[STAT_N-1:0];
   assign err_data_o  = wdata_i[ERR_N-1:0];

   always_comb begin
      unique case (sel)
         RA_STAT_FLAG: rdata_o = DATA_W'(stat_flag_i);
         RA_STAT_EN:   rdata_o = DATA_W'(stat_en_i);
         RA_ERR_FLAG:  rdata_o = DATA_W'(err_flag_i);
         RA_ERR_EN:    rdata_o = DATA_W'(err_en_i);
         default:      rdata_o = '0;
      endcase
   end

endmodule

// File: rtl/usb_irq_funnel.sv
`timescale 1ns/1ps
module usb_irq_funnel #(
   parameter int DATA_W     = 8,
   parameter int STAT_EVT_N = 6,
   parameter int ERR_N      = 6
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [STAT_EVT_N-1:0] stat_evt_i,
   input  logic [ERR_N-1:0]      err_evt_i,
   input  logic [1:0]            reg_addr_i,
   input  logic                  reg_wr_i,
   input  logic [DATA_W-1:0]     reg_wdata_i,
   output logic [DATA_W-1:0]     reg_rdata_o,
   output logic                  irq_o
);

   localparam int STAT_N  = STAT_EVT_N + 1;
   localparam int SUM_BIT = STAT_EVT_N;

   if (STAT_EVT_N < 1 || ERR_N < 1) begin : g_bad_counts
      $error("usb_irq_funnel: each tier needs at least one event");
   end

   logic              stat_clr_wr, stat_en_wr, err_clr_wr, err_en_wr;
   logic [STAT_N-1:0] stat_data;
   logic [ERR_N-1:0]  err_data;
   logic [STAT_N-1:0] stat_flag, stat_en, stat_set;
   logic [ERR_N-1:0]  err_flag, err_en;
   logic              err_pend, stat_pend;
   logic              irq_q;

   usb_irq_regif #(
      .DATA_W (DATA_W),
      .STAT_N (STAT_N),
      .ERR_N  (ERR_N)
   ) u_regif (
      .addr_i        (reg_addr_i),
      .wr_i          (reg_wr_i),
      .wdata_i       (reg_wdata_i),
      .stat_flag_i   (stat_flag),
      .stat_en_i     (stat_en),
      .err_flag_i    (err_flag),
      .err_en_i      (err_en),
      .stat_clr_wr_o (stat_clr_wr),
      .stat_en_wr_o  (stat_en_wr),
      .err_clr_wr_o  (err_clr_wr),
      .err_en_wr_o   (err_en_wr),
      .stat_data_o   (stat_data),
      .err_data_o    (err_data),
      .rdata_o       (reg_rdata_o)
   );

   usb_irq_bank #(.W(ERR_N)) u_err_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (err_evt_i),
      .clr_wr_i   (err_clr_wr),
      .clr_mask_i (err_data),
      .en_wr_i    (err_en_wr),
      .en_data_i  (err_data),
      .flag_o     (err_flag),
      .en_o       (err_en),
      .pend_o     (err_pend)
   );

   // summary is re-asserted every cycle an enabled error flag is held
   assign stat_set = {err_pend, stat_evt_i};

   usb_irq_bank #(.W(STAT_N)) u_stat_bank (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .set_i      (stat_set),
      .clr_wr_i   (stat_clr_wr),
      .clr_mask_i (stat_data),
      .en_wr_i    (stat_en_wr),
      .en_data_i  (stat_data),
      .flag_o     (stat_flag),
      .en_o       (stat_en),
      .pend_o     (stat_pend)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= stat_pend;
      end
   end

   assign irq_o = irq_q;

   // R7
   summary_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_pend |=> stat_flag[SUM_BIT]);

   // R8
   summary_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_flag[SUM_BIT] && err_pend) |=> stat_flag[SUM_BIT]);

   // R9
   irq_masked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_en == '0) |=> !irq_o);

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_flag == '0) |=> !irq_o);

endmodule

// File: tb/usb_irq_funnel_bench.sv
`timescale 1ns/1ps
module usb_irq_funnel_bench;

   localparam logic [1:0] A_SF = 2'd0, A_SE = 2'd1, A_EF = 2'd2, A_EE = 2'd3;
   localparam logic [7:0] B_RST = 8'h01, B_SOF = 8'h02, B_XACT = 8'h04;
   localparam logic [7:0] B_STALL = 8'h10, B_ACT = 8'h20, B_SUM = 8'h40;
   localparam logic [7:0] E_PID = 8'h01, E_CRC16 = 8'h04, E_STUFF = 8'h20;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [5:0] stat_evt = '0;
   logic [5:0] err_evt = '0;
   logic [1:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int n_run = 0;
   int n_fail = 0;

   always #10 clk = ~clk;

   usb_irq_funnel u_usb_irq_funnel (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .stat_evt_i  (stat_evt),
      .err_evt_i   (err_evt),
      .reg_addr_i  (reg_addr),
      .reg_wr_i    (reg_wr),
      .reg_wdata_i (reg_wdata),
      .reg_rdata_o (reg_rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic pulse(input logic [5:0] s, input logic [5:0] e);
      stat_evt = s; err_evt = e;
      @(negedge clk);
      stat_evt = '0; err_evt = '0;
   endtask

   task automatic t_reset();
      rd_chk("R10 stat flags", A_SF, 8'h00);
      rd_chk("R10 stat en", A_SE, 8'h00);
      rd_chk("R10 err flags", A_EF, 8'h00);
      rd_chk("R10 err en", A_EE, 8'h00);
      chk("R10 irq", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_latch_masked();
      pulse(B_SOF[5:0], E_CRC16[5:0]);
      rd_chk("R4 R2 sof latched while disabled", A_SF, B_SOF);
      rd_chk("R4 R3 crc16 latched while disabled", A_EF, E_CRC16);
      tick();
      chk("R9 no irq with enables off", {7'd0, irq}, 8'h00);
      rd_chk("R7 masked error leaves summary clear", A_SF, B_SOF);
   endtask

   task automatic t_enable_irq();
      wr(A_SE, B_SOF);
      chk("R9 irq not yet after enable write", {7'd0, irq}, 8'h00);
      rd_chk("R5 R1 enable readback", A_SE, B_SOF);
      tick();
      chk("R9 irq one clock after enable", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_w1c();
      pulse(B_RST[5:0], 6'd0);
      rd_chk("R2 bus reset bit", A_SF, B_RST | B_SOF);
      wr(A_SF, B_SOF);
      rd_chk("R5 clear only ones", A_SF, B_RST);
      chk("R9 irq holds for one clock", {7'd0, irq}, 8'h01);
      tick();
      chk("R9 irq falls after clear", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_set_wins();
      stat_evt = B_XACT[5:0];
      wr(A_SF, B_XACT);
      stat_evt = '0;
      rd_chk("R6 event beats clear", A_SF, B_RST | B_XACT);
      wr(A_SF, B_RST | B_XACT);
      rd_chk("R5 cleared", A_SF, 8'h00);
   endtask

   task automatic t_err_chain();
      wr(A_EF, 8'h3F);
      rd_chk("R5 err flags cleared", A_EF, 8'h00);
      wr(A_EE, E_PID);
      wr(A_SE, B_SUM);
      pulse(6'd0, E_PID[5:0]);
      rd_chk("R3 pid flag", A_EF, E_PID);
      rd_chk("R7 summary not yet", A_SF, 8'h00);
      tick();
      rd_chk("R7 summary set", A_SF, B_SUM);
      chk("R9 irq not yet", {7'd0, irq}, 8'h00);
      tick();
      chk("R9 irq from summary", {7'd0, irq}, 8'h01);
   endtask

   task automatic t_sum_sticky();
      wr(A_SF, B_SUM);
      rd_chk("R8 summary held by error", A_SF, B_SUM);
      wr(A_EF, E_PID);
      rd_chk("R8 error cleared", A_EF, 8'h00);
      rd_chk("R8 summary still set", A_SF, B_SUM);
      wr(A_SF, B_SUM);
      rd_chk("R8 summary clears", A_SF, 8'h00);
      tick();
      chk("R9 irq drops", {7'd0, irq}, 8'h00);
   endtask

   task automatic t_enable_late();
      pulse(6'd0, E_STUFF[5:0]);
      tick();
      rd_chk("R7 disabled stuff error", A_SF, 8'h00);
      wr(A_EE, E_STUFF | E_PID);
      rd_chk("R7 summary one clock after enable", A_SF, 8'h00);
      tick();
      rd_chk("R7 late enable sets summary", A_SF, B_SUM);
      wr(A_EF, E_STUFF);
      wr(A_SF, B_SUM);
      rd_chk("R8 cleanup", A_SF, 8'h00);
   endtask

   task automatic t_multi();
      wr(A_SE, 8'h7F);
      pulse(B_STALL[5:0] | B_ACT[5:0], 6'd0);
      tick();
      chk("R9 irq from two flags", {7'd0, irq}, 8'h01);
      wr(A_SF, B_STALL);
      tick();
      chk("R9 irq stays with one left", {7'd0, irq}, 8'h01);
      wr(A_SF, B_ACT);
      tick();
      chk("R9 irq falls after last", {7'd0, irq}, 8'h00);
      rd_chk("R1 err en readback", A_EE, E_STUFF | E_PID);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      t_reset();
      t_latch_masked();
      t_enable_irq();
      t_w1c();
      t_set_wins();
      t_err_chain();
      t_sum_sticky();
      t_enable_late();
      t_multi();
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(20 * 200000);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule